// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo audio stream arriving on three wires (a bit clock, a channel-select line and a serial data line) and turns it into parallel left and right samples with a one-cycle valid strobe. All three wires are brought into a single system clock that runs much faster than the bit clock. The block finds bit-clock rising edges in that domain and reads channel select and data on those edges.

A static two-bit format code picks one of four framings. The first is the standard I2S framing, where the most significant bit follows the channel-select change by one bit clock and up to 20 bits are kept. The other three are right-aligned framings of 16, 18 or 20 bits, where the sample occupies the last bits before each channel-select change. Samples leave the block as 20-bit signed values, left-aligned. A mute input forces both sample outputs to zero while it is held high.

Top module: `serial_audio_rx`

## Requirements
- R1: The format code selects the framing: 2'b00 is I2S, 2'b01 is right-aligned 16 bits, 2'b10 is right-aligned 18 bits and 2'b11 is right-aligned 20 bits.
- R2: In I2S framing, the first 20 bits after the bit-clock rise at which a channel-select change is seen form the sample, MSB first. The bit at that change rise and every bit after the 20th are ignored, and a shorter word reads back with zeros in its low bits.
- R3: In right-aligned framing with length N, the sample is the last N bits received before the bit-clock rise at which the channel-select change is seen. Earlier bits in that half-frame have no effect.
- R4: Channel select and data are read only at bit-clock rising edges. Each input passes two synchronizer flops and an edge-detect flop, so the strobe rises after the third system-clock edge that samples the closing bit-clock rise.
- R5: Channel select low marks the left word and high marks the right word. The valid strobe follows only the completion of a right word, and both outputs change at that strobe.
- R6: The valid strobe is one system-clock cycle wide. With mute unchanged, both outputs hold their values between strobes.
- R7: While mute is high, both outputs read zero and the strobe still pulses. When mute is released, the last received pair reappears.
- R8: After reset, both outputs are zero and valid is low. The first bit-clock rise after reset only records the channel-select level and does not end a word.
- R9: Outputs are 20-bit, left-aligned, and words shorter than 20 bits are padded with zeros in the low bits.
- R10: Half-frames of any length up to 32 bit clocks are accepted, including a 24-bit-clock half-frame carrying a 20-bit right-aligned word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk_in | input | 1 | Serial bit clock, asynchronous to clk |
| chan_sel_in | input | 1 | Channel select: low left, high right |
| ser_data_in | input | 1 | Serial data, MSB first |
| fmt_code | input | 2 | Framing select (see R1) |
| mute | input | 1 | Forces both sample outputs to zero |
| left_sample | output | 20 | Left sample, signed, left-aligned |
| right_sample | output | 20 | Right sample, signed, left-aligned |
| sample_valid | output | 1 | One-cycle strobe when a new pair is present |

## Verification
The hardest case to reach from the ports is a word boundary in which the bits that must be dropped differ from the bits that must be kept. Examples are an I2S word longer than 20 bits with non-zero tail bits, and a right-aligned half-frame whose leading filler is all ones. The stimulus builds each half-frame bit by bit, with filler chosen to corrupt the result if the wrong window were taken. It uses a 24-bit-clock half-frame for the 20-bit right-aligned case. A behavioural model reproduces the synchronizer delay from a history of the driven pins and is compared with the outputs on every clock.

// File: rtl/serial_audio_pkg.sv
package serial_audio_pkg;

   typedef enum logic [1:0] {
      FMT_I2S  = 2'b00,
      FMT_RJ16 = 2'b01,
      FMT_RJ18 = 2'b10,
      FMT_RJ20 = 2'b11
   } fmt_e;

   typedef enum logic {
      CH_LEFT  = 1'b0,
      CH_RIGHT = 1'b1
   } chan_e;

   localparam int NUM_RJ     = 3;
   localparam int RJ_MAX_LEN = 20;

   function automatic int rj_len(input int k);
      return 16 + 2 * k;
   endfunction

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sar_slot_tracker.sv
module sar_slot_tracker #(
   parameter int SLOT_MAX = 32,
   parameter int CNT_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_s,
   input  logic             sel_s,
   input  logic             data_s,
   output logic             bit_stb,
   output logic             bit_val,
   output logic             half_start,
   output logic             frame_edge,
   output logic             ended_chan,
   output logic [CNT_W-1:0] slot_idx
);
   localparam logic [CNT_W-1:0] SAT = CNT_W'(SLOT_MAX);

   logic             bclk_q;
   logic             primed_q;
   logic             sel_prev_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sel_change;

   assign bit_stb    = bclk_s & ~bclk_q;
   assign bit_val    = data_s;
   assign sel_change = primed_q & (sel_s != sel_prev_q);
   assign half_start = bit_stb & (~primed_q | sel_change);
   assign frame_edge = bit_stb & sel_change;
   assign ended_chan = sel_prev_q;

   always_comb begin
      if (half_start)      slot_idx = '0;
      else if (cnt_q == SAT) slot_idx = SAT;
      else                 slot_idx = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q     <= 1'b0;
         primed_q   <= 1'b0;
         sel_prev_q <= 1'b0;
         cnt_q      <= '0;
      end else begin
         bclk_q <= bclk_s;
         if (bit_stb) begin
            primed_q <= 1'b1;
            cnt_q    <= slot_idx;
            if (half_start) sel_prev_q <= sel_s;
         end
      end
   end
endmodule

// File: rtl/sar_word_capture.sv
module sar_word_capture
   import serial_audio_pkg::*;
#(
   parameter int SAMPLE_W = 20,
   parameter int SLOT_MAX = 32,
   parameter int CNT_W    = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  fmt_e                fmt,
   input  logic                bit_stb,
   input  logic                bit_val,
   input  logic                half_start,
   input  logic [CNT_W-1:0]    slot_idx,
   output logic [SAMPLE_W-1:0] word
);
   logic [SLOT_MAX-1:0]             shift_q;
   logic [SAMPLE_W-1:0]             i2s_q;
   logic [SAMPLE_W-1:0]             set_mask;
   logic [NUM_RJ-1:0][SAMPLE_W-1:0] rj_word;

   // one-hot position for I2S bit k (k = 1 is the MSB)
   always_comb begin
      set_mask = '0;
      for (int k = 1; k <= SAMPLE_W; k++) begin
         if (slot_idx == CNT_W'(k)) set_mask[SAMPLE_W-k] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         i2s_q   <= '0;
      end else if (bit_stb) begin
         shift_q <= {shift_q[SLOT_MAX-2:0], bit_val};
         if (half_start) i2s_q <= '0;
         else            i2s_q <= (i2s_q & ~set_mask) | (bit_val ? set_mask : '0);
      end
   end

   for (genvar g = 0; g < NUM_RJ; g++) begin : g_rj
      localparam int LEN = rj_len(g);
      if (SAMPLE_W > LEN) begin : g_pad
         assign rj_word[g] = {shift_q[LEN-1:0], {(SAMPLE_W-LEN){1'b0}}};
      end else begin : g_exact
         assign rj_word[g] = shift_q[LEN-1:0];
      end
   end

   always_comb begin
      case (fmt)
         FMT_RJ16: word = rj_word[0];
         FMT_RJ18: word = rj_word[1];
         FMT_RJ20: word = rj_word[2];
         default:  word = i2s_q;
      endcase
   end
endmodule

// File: rtl/sar_out_stage.sv
module sar_out_stage
   import serial_audio_pkg::*;
#(
   parameter int SAMPLE_W = 20
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                frame_edge,
   input  logic                ended_chan,
   input  logic [SAMPLE_W-1:0] word,
   input  logic                mute,
   output logic [SAMPLE_W-1:0] left_out,
   output logic [SAMPLE_W-1:0] right_out,
   output logic                valid_out
);
   logic [SAMPLE_W-1:0] hold_q;
   logic [SAMPLE_W-1:0] left_q;
   logic [SAMPLE_W-1:0] right_q;
   logic                valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '0;
         left_q  <= '0;
         right_q <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (frame_edge) begin
            if (chan_e'(ended_chan) == CH_LEFT) begin
               hold_q <= word;
            end else begin
               left_q  <= hold_q;
               right_q <= word;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign left_out  = mute ? '0 : left_q;
   assign right_out = mute ? '0 : right_q;
   assign valid_out = valid_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import serial_audio_pkg::*;
#(
   parameter int SAMPLE_W    = 20,
   parameter int SLOT_MAX    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_clk_in,
   input  logic                chan_sel_in,
   input  logic                ser_data_in,
   input  logic [1:0]          fmt_code,
   input  logic                mute,
   output logic [SAMPLE_W-1:0] left_sample,
   output logic [SAMPLE_W-1:0] right_sample,
   output logic                sample_valid
);
   localparam int CNT_W = $clog2(SLOT_MAX + 1);

   if (SAMPLE_W < RJ_MAX_LEN) begin : g_bad_width
      $error("SAMPLE_W must hold the longest right-aligned word");
   end
   if (SLOT_MAX < SAMPLE_W) begin : g_bad_slots
      $error("SLOT_MAX must not be below SAMPLE_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]          pins_s;
   logic                bit_stb;
   logic                bit_val;
   logic                half_start;
   logic                frame_edge;
   logic                ended_chan;
   logic [CNT_W-1:0]    slot_idx;
   logic [SAMPLE_W-1:0] word;

   sar_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bit_clk_in, chan_sel_in, ser_data_in}),
      .q     (pins_s)
   );

   sar_slot_tracker #(.SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_s     (pins_s[2]),
      .sel_s      (pins_s[1]),
      .data_s     (pins_s[0]),
      .bit_stb    (bit_stb),
      .bit_val    (bit_val),
      .half_start (half_start),
      .frame_edge (frame_edge),
      .ended_chan (ended_chan),
      .slot_idx   (slot_idx)
   );

   sar_word_capture #(.SAMPLE_W(SAMPLE_W), .SLOT_MAX(SLOT_MAX), .CNT_W(CNT_W)) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .fmt        (fmt_e'(fmt_code)),
      .bit_stb    (bit_stb),
      .bit_val    (bit_val),
      .half_start (half_start),
      .slot_idx   (slot_idx),
      .word       (word)
   );

   sar_out_stage #(.SAMPLE_W(SAMPLE_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_edge (frame_edge),
      .ended_chan (ended_chan),
      .word       (word),
      .mute       (mute),
      .left_out   (left_sample),
      .right_out  (right_sample),
      .valid_out  (sample_valid)
   );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
   parameter int SAMPLE_W = 20
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mute,
   input logic [SAMPLE_W-1:0] left_sample,
   input logic [SAMPLE_W-1:0] right_sample,
   input logic                sample_valid,
   input logic                bit_stb,
   input logic                frame_edge,
   input logic                ended_chan
);
   // R6: strobe lasts a single cycle
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |=> !sample_valid);

   // R6: outputs only move at a strobe or a mute change
   p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(mute) && !$rose(sample_valid)) |-> ($stable(left_sample) && $stable(right_sample)));

   // R5: a strobe follows only the end of a right word
   p_valid_after_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_valid |-> $past(frame_edge && ended_chan));

   // R4: a bit-clock rise is seen as an isolated one-cycle event
   p_rise_isolated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |=> !bit_stb);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mute         (mute),
   .left_sample  (left_sample),
   .right_sample (right_sample),
   .sample_valid (sample_valid),
   .bit_stb      (bit_stb),
   .frame_edge   (frame_edge),
   .ended_chan   (ended_chan)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_BCK   = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bck = 1'b0;
   logic        wsel = 1'b0;
   logic        sdat = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic        mute = 1'b0;
   logic [19:0] left_sample;
   logic [19:0] right_sample;
   logic        sample_valid;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_audio_rx u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_clk_in   (bck),
      .chan_sel_in  (wsel),
      .ser_data_in  (sdat),
      .fmt_code     (fmt),
      .mute         (mute),
      .left_sample  (left_sample),
      .right_sample (right_sample),
      .sample_valid (sample_valid)
   );

   // ---------------- behavioural reference model ----------------
   bit          hb[4], hw[4], hd[4];
   bit          bq[$];
   bit          m_primed, m_wsp, m_v;
   logic [19:0] m_hold, m_l, m_r;

   function automatic logic [19:0] model_word(input logic [1:0] f);
      logic [19:0] raw = '0;
      int n;
      if (f == 2'b00) begin
         for (int k = 1; k <= 20; k++)
            if (k < bq.size()) raw[20-k] = bq[k];
         return raw;
      end
      n = (f == 2'b01) ? 16 : (f == 2'b10) ? 18 : 20;
      for (int j = 0; j < n; j++) begin
         int idx = bq.size() - 1 - j;
         if (idx >= 0) raw[j] = bq[idx];
      end
      return raw << (20 - n);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin hb[i] = 0; hw[i] = 0; hd[i] = 0; end
         bq.delete();
         m_primed = 0; m_wsp = 0; m_v = 0;
         m_hold = '0; m_l = '0; m_r = '0;
      end else begin
         for (int i = 3; i > 0; i--) begin hb[i] = hb[i-1]; hw[i] = hw[i-1]; hd[i] = hd[i-1]; end
         hb[0] = bck; hw[0] = wsel; hd[0] = sdat;
         m_v = 0;
         if (hb[2] && !hb[3]) begin
            if (!m_primed) begin
               m_primed = 1; m_wsp = hw[2]; bq.delete(); bq.push_back(hd[2]);
            end else if (hw[2] != m_wsp) begin
               if (!m_wsp) m_hold = model_word(fmt);
               else begin m_l = m_hold; m_r = model_word(fmt); m_v = 1; end
               m_wsp = hw[2]; bq.delete(); bq.push_back(hd[2]);
            end else begin
               bq.push_back(hd[2]);
            end
         end
      end
   end

   // per-clock comparison (R4 R5 R6 R7)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         logic [19:0] el, er;
         el = mute ? '0 : m_l;
         er = mute ? '0 : m_r;
         checks++;
         if (left_sample !== el || right_sample !== er || sample_valid !== m_v) begin
            errors++;
            $display("FAIL R4 R5 R6 model t=%0t: got l=%h r=%h v=%b exp l=%h r=%h v=%b",
                     $time, left_sample, right_sample, sample_valid, el, er, m_v);
         end
      end
   end

   // ---------------- capture of output pairs ----------------
   logic [19:0] got_l[$], got_r[$], exp_l[$], exp_r[$];

   always @(negedge clk) begin
      if (rst_n && sample_valid) begin
         got_l.push_back(left_sample);
         got_r.push_back(right_sample);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic slot(input bit ws, input bit d);
      bck = 1'b0; wsel = ws; sdat = d;
      tick(HALF_BCK);
      bck = 1'b1;
      tick(HALF_BCK);
   endtask

   function automatic int fmt_len(input logic [1:0] f);
      return (f == 2'b01) ? 16 : (f == 2'b10) ? 18 : 20;
   endfunction

   // expected output from the requirements (R2, R3, R9)
   function automatic logic [19:0] exp_word(input logic [1:0] f, input logic [23:0] w);
      int n;
      logic [23:0] m;
      if (f == 2'b00) return w[23:4];
      n = fmt_len(f);
      m = (24'h1 << n) - 1;
      return 20'((w & m) << (20 - n));
   endfunction

   task automatic play_half(input bit ws, input logic [1:0] f, input int h, input logic [23:0] w);
      logic [31:0] vec;
      int n;
      if (f == 2'b00) vec = {1'b0, w, 7'b0};
      else begin
         n = fmt_len(f);
         vec = (32'hFFFF_FFFF << n) | (32'(w) & ((32'h1 << n) - 1));
      end
      for (int i = 0; i < h; i++) slot(ws, vec[h-1-i]);
   endtask

   task automatic send_pair(input logic [1:0] f, input int h,
                            input logic [23:0] l, input logic [23:0] r);
      play_half(1'b0, f, h, l);
      play_half(1'b1, f, h, r);
      exp_l.push_back(mute ? 20'h0 : exp_word(f, l));
      exp_r.push_back(mute ? 20'h0 : exp_word(f, r));
   endtask

   task automatic close_and_check(input string tag);
      slot(1'b0, 1'b0);
      tick(8);
      checks++;
      if (got_l.size() != exp_l.size()) begin
         errors++;
         $display("FAIL %s pair count: got %0d exp %0d", tag, got_l.size(), exp_l.size());
      end
      while (exp_l.size() > 0) begin
         logic [19:0] el, er, gl, gr;
         el = exp_l.pop_front(); er = exp_r.pop_front();
         gl = (got_l.size() > 0) ? got_l.pop_front() : 20'hxxxxx;
         gr = (got_r.size() > 0) ? got_r.pop_front() : 20'hxxxxx;
         checks++;
         if (gl !== el || gr !== er) begin
            errors++;
            $display("FAIL %s pair: got l=%h r=%h exp l=%h r=%h", tag, gl, gr, el, er);
         end
      end
      got_l.delete(); got_r.delete();
   endtask

   task automatic do_reset();
      rst_n = 1'b0; bck = 1'b0; wsel = 1'b0; sdat = 1'b0;
      tick(4);
      rst_n = 1'b1;
      tick(2);
   endtask

   task automatic check_out(input string tag, input logic [19:0] el,
                            input logic [19:0] er, input bit ev);
      checks++;
      if (left_sample !== el || right_sample !== er || sample_valid !== ev) begin
         errors++;
         $display("FAIL %s: got l=%h r=%h v=%b exp l=%h r=%h v=%b",
                  tag, left_sample, right_sample, sample_valid, el, er, ev);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      tick(3);
      check_out("R8 in reset", 20'h0, 20'h0, 1'b0);
      do_reset();
      check_out("R8 after reset", 20'h0, 20'h0, 1'b0);

      // R1 R2: I2S, 24-bit words with non-zero tail bits, a 16-bit word (R9)
      fmt = 2'b00;
      send_pair(2'b00, 32, 24'hABCDE5, 24'h123457);
      send_pair(2'b00, 32, 24'h800001, 24'h7FFFF0);
      send_pair(2'b00, 32, 24'hBEEF00, 24'h00F00F);
      close_and_check("R1 R2 R9 i2s");

      do_reset();
      check_out("R8 second reset", 20'h0, 20'h0, 1'b0);

      // R3 R9: right-aligned 16 with all-ones filler
      fmt = 2'b01;
      tick(1);
      send_pair(2'b01, 32, 24'h001234, 24'h00FFFF);
      send_pair(2'b01, 32, 24'h008000, 24'h000001);
      close_and_check("R1 R3 R9 rj16");

      do_reset();
      fmt = 2'b10;
      tick(1);
      send_pair(2'b10, 32, 24'h02ABCD, 24'h015432);
      close_and_check("R1 R3 rj18");

      // R10: 24-slot half-frames with 20-bit words
      do_reset();
      fmt = 2'b11;
      tick(1);
      send_pair(2'b11, 24, 24'h0FEDCB, 24'h000001);
      send_pair(2'b11, 24, 24'h080000, 24'h07FFFF);
      close_and_check("R10 R3 rj20");

      // R7: mute zeroes outputs, strobe still pulses, release restores
      do_reset();
      fmt = 2'b00;
      mute = 1'b1;
      tick(1);
      send_pair(2'b00, 32, 24'h13579B, 24'h2468AC);
      send_pair(2'b00, 32, 24'h55AA50, 24'hC3C3C0);
      close_and_check("R7 muted");
      check_out("R7 muted hold", 20'h0, 20'h0, 1'b0);
      mute = 1'b0;
      tick(1);
      check_out("R7 released", 20'h55AA5, 20'hC3C3C, 1'b0);
      tick(20);
      check_out("R6 held", 20'h55AA5, 20'hC3C3C, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule